// File: doc/BRIEF.md
# Accumulator Bit-Field Position Extractor

This unit keeps a small bank of double-word accumulators, each split into a high and a low word, together with a six-bit bit pointer and a one-bit extract-failure flag. An extraction takes a field of size+1 bits whose most significant bit sits at the pointer and returns it right-justified. A consuming extraction also moves the pointer down past the field, so that a run of extractions walks a bit stream from the top down. If the field would reach below bit zero, the extraction fails. It then returns zero and raises the failure flag.

Two more operations work on a whole accumulator. The first is a signed logical shift: a non-negative amount shifts right, a negative amount shifts left by its magnitude. The second is a word push: the old low word moves into the high word, a new low word is loaded, and the pointer advances by one word width. A set-control operation loads the pointer and the flag from fixed bit positions of the register operand. Instruction decode is done elsewhere. This block receives an operation code and its operands, one operation per cycle.

Top module: `acc_field_extractor`

## Requirements
- R1: After reset every accumulator is zero, the pointer is 0, the failure flag is 0 and resultValid is 0.
- R2: Operation codes are 1 extract, 2 extract-and-consume, 3 shift, 4 push, 5 set-control. An extract returns accumulator bits pos down to pos-size, right-justified and zero-extended in resultOut. resultValid is high for exactly the cycle after the operation.
- R3: An extraction is valid only when pos >= size. A failing extraction returns 0 and sets the failure flag. A valid one clears the flag.
- R4: Extract-and-consume writes pos-size-1 modulo 64 into the pointer (63 when pos equals size), only on a valid extraction. A plain extract and a failing one leave the pointer unchanged.
- R5: With useRegOperand high, the size comes from regVal[4:0] and the shift amount from regVal[5:0], and sizeImm and shiftImm are ignored.
- R6: Push copies the old low word into the high word and loads regVal into the low word.
- R7: Push adds 32 to the pointer modulo 64 (32 becomes 0) unless the pointer is already above 32, in which case the pointer is kept.
- R8: Set-control loads the pointer from regVal[5:0] and the failure flag from regVal[14]. All other regVal bits are ignored.
- R9: Shift treats its six-bit amount as two's complement. Zero leaves the accumulator unchanged, a positive amount shifts right logically, and a negative amount shifts left by its magnitude (-32 shifts left by 32).
- R10: Shift and push write only the accumulator named by accSel. The others keep their contents.
- R11: Codes 0, 6 and 7, or opValid low, change no state and leave resultValid low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| opValid | input | 1 | An operation is presented this cycle |
| opSel | input | 3 | Operation code |
| accSel | input | 2 | Accumulator index for the operation and for the read-out |
| sizeImm | input | 5 | Immediate field size minus one |
| shiftImm | input | 6 | Immediate signed shift amount |
| useRegOperand | input | 1 | Take size or shift amount from regVal |
| regVal | input | 32 | Register operand |
| resultOut | output | 32 | Last extracted field |
| resultValid | output | 1 | resultOut was written by the previous operation |
| accHiOut | output | 32 | High word of the selected accumulator |
| accLoOut | output | 32 | Low word of the selected accumulator |
| posOut | output | 6 | Current bit pointer |
| failOut | output | 1 | Extract-failure flag |

## Verification
The assertions assume that the operation inputs are stable around the sampling edge. They also assume that accSel still names the same accumulator in the cycle after a push or shift, so that the read-out ports reflect the accumulator that was written. The bench changes every input on the falling edge, holds accSel until its checks are done, and keeps opValid low through reset, so no property sees an operation older than reset. The accumulator contents are built only through pushes and the pointer only through set-control and consume, so every expected value follows from earlier port-level operations.

// File: rtl/acc_field_pkg.sv
package acc_field_pkg;

  typedef enum logic [2:0] {
    OP_IDLE            = 3'd0,
    OP_EXTRACT         = 3'd1,
    OP_EXTRACT_CONSUME = 3'd2,
    OP_SHIFT           = 3'd3,
    OP_PUSH            = 3'd4,
    OP_SET_CTRL        = 3'd5
  } opCode_e;

  // strobes from control to datapath, valid in the cycle of the operation
  typedef struct packed {
    logic extract;  // load the result register
    logic fieldOk;  // field lies inside the accumulator
    logic shift;    // write the shifted accumulator back
    logic push;     // move low word up and load a new one
  } dpStrobe_t;

  localparam int FAIL_FLAG_BIT = 14;

endpackage

// File: rtl/acc_field_ctrl.sv
module acc_field_ctrl
  import acc_field_pkg::*;
#(
  parameter int WORD_W = 32,
  localparam int POS_W  = $clog2(2 * WORD_W),
  localparam int SIZE_W = $clog2(WORD_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              opValid,
  input  logic [2:0]        opSel,
  input  logic [SIZE_W-1:0] sizeImm,
  input  logic [POS_W-1:0]  shiftImm,
  input  logic              useRegOperand,
  input  logic [POS_W-1:0]  regLow,
  input  logic              regFlag,
  output dpStrobe_t         strobe,
  output logic [POS_W-1:0]  fieldLsb,
  output logic [SIZE_W-1:0] fieldSize,
  output logic [POS_W-1:0]  shiftAmount,
  output logic [POS_W-1:0]  posOut,
  output logic              failOut
);

  localparam logic [POS_W-1:0] PUSH_STEP = POS_W'(WORD_W);

  logic [POS_W-1:0] posQ, posD;
  logic             failQ, failD;
  logic [POS_W-1:0] sizeWide;
  logic             fieldOk;
  logic             isExtract, isConsume, isShift, isPush, isSetCtrl;

  always_comb begin
    isExtract = 1'b0;
    isConsume = 1'b0;
    isShift   = 1'b0;
    isPush    = 1'b0;
    isSetCtrl = 1'b0;
    if (opValid) begin
      case (opSel)
        3'(OP_EXTRACT):         isExtract = 1'b1;
        3'(OP_EXTRACT_CONSUME): begin isExtract = 1'b1; isConsume = 1'b1; end
        3'(OP_SHIFT):           isShift   = 1'b1;
        3'(OP_PUSH):            isPush    = 1'b1;
        3'(OP_SET_CTRL):        isSetCtrl = 1'b1;
        default:                ;
      endcase
    end
  end

  // operand selection
  assign fieldSize   = useRegOperand ? regLow[SIZE_W-1:0] : sizeImm;
  assign shiftAmount = useRegOperand ? regLow : shiftImm;
  assign sizeWide    = POS_W'(fieldSize);

  // field fits when its lowest bit is at or above bit zero
  assign fieldOk  = (posQ >= sizeWide);
  assign fieldLsb = posQ - sizeWide;

  always_comb begin
    posD  = posQ;
    failD = failQ;
    if (isExtract) begin
      failD = ~fieldOk;
      if (isConsume && fieldOk) posD = posQ - sizeWide - POS_W'(1);
    end
    if (isPush && (posQ <= PUSH_STEP)) posD = posQ + PUSH_STEP;
    if (isSetCtrl) begin
      posD  = regLow;
      failD = regFlag;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      posQ  <= '0;
      failQ <= 1'b0;
    end else begin
      posQ  <= posD;
      failQ <= failD;
    end
  end

  assign strobe.extract = isExtract;
  assign strobe.fieldOk = fieldOk;
  assign strobe.shift   = isShift;
  assign strobe.push    = isPush;

  assign posOut  = posQ;
  assign failOut = failQ;

endmodule

// File: rtl/acc_field_shifter.sv
module acc_field_shifter #(
  parameter int WORD_W = 32,
  localparam int ACC_W = 2 * WORD_W,
  localparam int POS_W = $clog2(ACC_W)
) (
  input  logic [ACC_W-1:0] accIn,
  input  logic [POS_W-1:0] amount,
  output logic [ACC_W-1:0] accOut
);

  logic [POS_W-1:0] magnitude;

  // negation of the most negative code yields its own magnitude (WORD_W)
  assign magnitude = POS_W'(-amount);

  always_comb begin
    if (amount[POS_W-1]) accOut = accIn << magnitude;
    else                 accOut = accIn >> amount;
  end

endmodule

// File: rtl/acc_field_datapath.sv
module acc_field_datapath
  import acc_field_pkg::*;
#(
  parameter int ACC_COUNT = 4,
  parameter int WORD_W    = 32,
  localparam int ACC_W     = 2 * WORD_W,
  localparam int POS_W     = $clog2(ACC_W),
  localparam int SIZE_W    = $clog2(WORD_W),
  localparam int ACC_IDX_W = (ACC_COUNT > 1) ? $clog2(ACC_COUNT) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  dpStrobe_t            strobe,
  input  logic [ACC_IDX_W-1:0] accSel,
  input  logic [POS_W-1:0]     fieldLsb,
  input  logic [SIZE_W-1:0]    fieldSize,
  input  logic [POS_W-1:0]     shiftAmount,
  input  logic [WORD_W-1:0]    regVal,
  output logic [WORD_W-1:0]    resultOut,
  output logic                 resultValid,
  output logic [WORD_W-1:0]    accHiOut,
  output logic [WORD_W-1:0]    accLoOut
);

  localparam logic [SIZE_W-1:0] TOP_SIZE = SIZE_W'(WORD_W - 1);

  logic [ACC_W-1:0]  bank [ACC_COUNT];
  logic [ACC_W-1:0]  selAcc;
  logic [ACC_W-1:0]  shiftedAcc;
  logic [ACC_W-1:0]  nextAcc;
  logic [WORD_W-1:0] fieldBits;
  logic [WORD_W-1:0] fieldMask;
  logic [WORD_W-1:0] resultQ;
  logic              validQ;

  assign selAcc = bank[accSel];

  acc_field_shifter #(.WORD_W(WORD_W)) shifter_i (
    .accIn (selAcc),
    .amount(shiftAmount),
    .accOut(shiftedAcc)
  );

  always_comb begin
    if (strobe.push) nextAcc = {selAcc[WORD_W-1:0], regVal};
    else             nextAcc = shiftedAcc;
  end

  // one register per accumulator, written only when selected
  for (genvar g = 0; g < ACC_COUNT; g++) begin : g_acc
    logic [ACC_W-1:0] accQ;
    logic             writeEn;
    assign writeEn = (strobe.shift || strobe.push) && (accSel == ACC_IDX_W'(g));
    always_ff @(posedge clk) begin
      if (!rst_n)       accQ <= '0;
      else if (writeEn) accQ <= nextAcc;
    end
    assign bank[g] = accQ;
  end

  // field extraction: align lowest field bit to bit zero, then mask
  assign fieldBits = WORD_W'(selAcc >> fieldLsb);
  assign fieldMask = {WORD_W{1'b1}} >> (TOP_SIZE - fieldSize);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      resultQ <= '0;
      validQ  <= 1'b0;
    end else begin
      validQ <= strobe.extract;
      if (strobe.extract) resultQ <= strobe.fieldOk ? (fieldBits & fieldMask) : '0;
    end
  end

  assign resultOut   = resultQ;
  assign resultValid = validQ;
  assign accHiOut    = selAcc[ACC_W-1:WORD_W];
  assign accLoOut    = selAcc[WORD_W-1:0];

endmodule

// File: rtl/acc_field_extractor.sv
module acc_field_extractor
  import acc_field_pkg::*;
#(
  parameter int ACC_COUNT = 4,
  parameter int WORD_W    = 32,
  localparam int POS_W     = $clog2(2 * WORD_W),
  localparam int SIZE_W    = $clog2(WORD_W),
  localparam int ACC_IDX_W = (ACC_COUNT > 1) ? $clog2(ACC_COUNT) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 opValid,
  input  logic [2:0]           opSel,
  input  logic [ACC_IDX_W-1:0] accSel,
  input  logic [SIZE_W-1:0]    sizeImm,
  input  logic [POS_W-1:0]     shiftImm,
  input  logic                 useRegOperand,
  input  logic [WORD_W-1:0]    regVal,
  output logic [WORD_W-1:0]    resultOut,
  output logic                 resultValid,
  output logic [WORD_W-1:0]    accHiOut,
  output logic [WORD_W-1:0]    accLoOut,
  output logic [POS_W-1:0]     posOut,
  output logic                 failOut
);

  dpStrobe_t         strobe;
  logic [POS_W-1:0]  fieldLsb;
  logic [SIZE_W-1:0] fieldSize;
  logic [POS_W-1:0]  shiftAmount;

  acc_field_ctrl #(.WORD_W(WORD_W)) ctrl_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .opValid      (opValid),
    .opSel        (opSel),
    .sizeImm      (sizeImm),
    .shiftImm     (shiftImm),
    .useRegOperand(useRegOperand),
    .regLow       (regVal[POS_W-1:0]),
    .regFlag      (regVal[FAIL_FLAG_BIT]),
    .strobe       (strobe),
    .fieldLsb     (fieldLsb),
    .fieldSize    (fieldSize),
    .shiftAmount  (shiftAmount),
    .posOut       (posOut),
    .failOut      (failOut)
  );

  acc_field_datapath #(.ACC_COUNT(ACC_COUNT), .WORD_W(WORD_W)) dp_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .strobe     (strobe),
    .accSel     (accSel),
    .fieldLsb   (fieldLsb),
    .fieldSize  (fieldSize),
    .shiftAmount(shiftAmount),
    .regVal     (regVal),
    .resultOut  (resultOut),
    .resultValid(resultValid),
    .accHiOut   (accHiOut),
    .accLoOut   (accLoOut)
  );

endmodule

// File: rtl/acc_field_extractor_checker.sv
module acc_field_extractor_checker
  import acc_field_pkg::*;
#(
  parameter int ACC_COUNT = 4,
  parameter int WORD_W    = 32,
  localparam int POS_W     = $clog2(2 * WORD_W),
  localparam int SIZE_W    = $clog2(WORD_W),
  localparam int ACC_IDX_W = (ACC_COUNT > 1) ? $clog2(ACC_COUNT) : 1
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 opValid,
  input logic [2:0]           opSel,
  input logic [ACC_IDX_W-1:0] accSel,
  input logic [SIZE_W-1:0]    sizeImm,
  input logic [POS_W-1:0]     shiftImm,
  input logic                 useRegOperand,
  input logic [WORD_W-1:0]    regVal,
  input logic [WORD_W-1:0]    resultOut,
  input logic                 resultValid,
  input logic [WORD_W-1:0]    accHiOut,
  input logic [WORD_W-1:0]    accLoOut,
  input logic [POS_W-1:0]     posOut,
  input logic                 failOut
);

  localparam logic [POS_W-1:0] STEP = POS_W'(WORD_W);

  logic [SIZE_W-1:0] sizeNow;
  logic              anyExtract;
  assign sizeNow    = useRegOperand ? regVal[SIZE_W-1:0] : sizeImm;
  assign anyExtract = opValid && (opSel == 3'(OP_EXTRACT) || opSel == 3'(OP_EXTRACT_CONSUME));

  // R2: the result strobe follows exactly the extract operations
  assert_result_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
    anyExtract |=> resultValid);
  assert_no_strobe_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !anyExtract |=> !resultValid);

  // R3: failure flag reflects the fit test and a failed field reads as zero
  assert_fail_cond_R3: assert property (@(posedge clk) disable iff (!rst_n)
    anyExtract |=> failOut == ($past(posOut) < POS_W'($past(sizeNow))));
  assert_fail_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (resultValid && failOut) |-> resultOut == '0);

  // R4: a plain extract never moves the pointer
  assert_plain_keeps_pos_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (opValid && opSel == 3'(OP_EXTRACT)) |=> posOut == $past(posOut));

  // R6: push moves the old low word into the high word
  assert_push_moves_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (opValid && opSel == 3'(OP_PUSH)) |=>
      (accSel != $past(accSel)) || (accHiOut == $past(accLoOut) && accLoOut == $past(regVal)));

  // R7: push advances a low pointer by one word and keeps a high one
  assert_push_pos_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (opValid && opSel == 3'(OP_PUSH) && posOut <= STEP) |=> posOut == POS_W'($past(posOut) + STEP));
  assert_push_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (opValid && opSel == 3'(OP_PUSH) && posOut > STEP) |=> $stable(posOut));

  // R9: zero shift leaves the accumulator unchanged
  assert_zero_shift_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (opValid && opSel == 3'(OP_SHIFT) && (useRegOperand ? regVal[POS_W-1:0] : shiftImm) == '0) |=>
      (accSel != $past(accSel)) || ($stable(accHiOut) && $stable(accLoOut)));

endmodule

bind acc_field_extractor acc_field_extractor_checker #(
  .ACC_COUNT(ACC_COUNT),
  .WORD_W   (WORD_W)
) chk_i (.*);

// File: tb/acc_field_extractor_tb_top.sv
module acc_field_extractor_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        opValid = 1'b0;
  logic [2:0]  opSel = 3'd0;
  logic [1:0]  accSel = 2'd0;
  logic [4:0]  sizeImm = 5'd0;
  logic [5:0]  shiftImm = 6'd0;
  logic        useRegOperand = 1'b0;
  logic [31:0] regVal = 32'd0;
  logic [31:0] resultOut, accHiOut, accLoOut;
  logic        resultValid, failOut;
  logic [5:0]  posOut;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  acc_field_extractor dut_i (.*);

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [2:0] op, input logic [1:0] acc, input logic [4:0] sz,
                       input logic [5:0] sh, input logic useReg, input logic [31:0] rv);
    @(negedge clk);
    opValid = 1'b1; opSel = op; accSel = acc; sizeImm = sz;
    shiftImm = sh; useRegOperand = useReg; regVal = rv;
    @(posedge clk);
    #1;
    opValid = 1'b0; opSel = 3'd0; useRegOperand = 1'b0;
  endtask

  // junk in every bit except pointer and flag positions
  task automatic setCtrl(input logic [5:0] p, input logic f);
    issue(3'd5, 2'd0, 5'd0, 6'd0, 1'b0, (32'hFFFF_FFFF & ~32'h0000_403F) | (32'(f) << 14) | 32'(p));
  endtask

  task automatic loadAcc(input logic [1:0] acc, input logic [63:0] v);
    issue(3'd4, acc, 5'd0, 6'd0, 1'b0, v[63:32]);
    issue(3'd4, acc, 5'd0, 6'd0, 1'b0, v[31:0]);
  endtask

  task automatic readAcc(input logic [1:0] acc, output logic [63:0] v);
    @(negedge clk);
    accSel = acc;
    #1;
    v = {accHiOut, accLoOut};
  endtask

  function automatic logic [31:0] fieldOf(input logic [63:0] a, input int p, input int s);
    logic [63:0] sh;
    if (p < s) return 32'd0;
    sh = a >> (p - s);
    return sh[31:0] & (32'hFFFF_FFFF >> (31 - s));
  endfunction

  localparam logic [63:0] PATTERN = 64'h89AB_CDEF_0123_4567;

  task automatic testReset();
    logic [63:0] v;
    check("R1 pointer", 64'(posOut), 64'd0);
    check("R1 flag", 64'(failOut), 64'd0);
    check("R1 resultValid", 64'(resultValid), 64'd0);
    for (int i = 0; i < 4; i++) begin
      readAcc(2'(i), v);
      check("R1 accumulator", v, 64'd0);
    end
  endtask

  task automatic testPush();
    logic [63:0] v;
    issue(3'd4, 2'd0, 5'd0, 6'd0, 1'b0, PATTERN[63:32]);
    check("R6 push hi", 64'(accHiOut), 64'd0);
    check("R6 push lo", 64'(accLoOut), 64'(PATTERN[63:32]));
    check("R7 pointer 0 to 32", 64'(posOut), 64'd32);
    issue(3'd4, 2'd0, 5'd0, 6'd0, 1'b0, PATTERN[31:0]);
    check("R6 push second", {accHiOut, accLoOut}, PATTERN);
    check("R7 pointer 32 wraps to 0", 64'(posOut), 64'd0);
    setCtrl(6'd40, 1'b0);
    issue(3'd4, 2'd2, 5'd0, 6'd0, 1'b0, 32'h0000_0011);
    check("R7 pointer 40 kept", 64'(posOut), 64'd40);
    setCtrl(6'd33, 1'b0);
    issue(3'd4, 2'd2, 5'd0, 6'd0, 1'b0, 32'h0000_0022);
    check("R7 pointer 33 kept", 64'(posOut), 64'd33);
    check("R6 acc2 contents", {accHiOut, accLoOut}, 64'h0000_0011_0000_0022);
    readAcc(2'd0, v);
    check("R10 acc0 untouched by acc2 push", v, PATTERN);
  endtask

  task automatic testSetCtrl();
    setCtrl(6'd17, 1'b1);
    check("R8 pointer load", 64'(posOut), 64'd17);
    check("R8 flag load", 64'(failOut), 64'd1);
    setCtrl(6'd63, 1'b0);
    check("R8 pointer 63", 64'(posOut), 64'd63);
    check("R8 flag clear", 64'(failOut), 64'd0);
  endtask

  task automatic testExtract();
    setCtrl(6'd39, 1'b1);
    issue(3'd1, 2'd0, 5'd7, 6'd0, 1'b0, 32'd0);
    check("R2 byte field", 64'(resultOut), 64'(fieldOf(PATTERN, 39, 7)));
    check("R2 resultValid", 64'(resultValid), 64'd1);
    check("R3 valid clears flag", 64'(failOut), 64'd0);
    check("R4 plain keeps pointer", 64'(posOut), 64'd39);
    setCtrl(6'd63, 1'b0);
    issue(3'd1, 2'd0, 5'd31, 6'd0, 1'b0, 32'd0);
    check("R2 top word", 64'(resultOut), 64'h89AB_CDEF);
    setCtrl(6'd31, 1'b0);
    issue(3'd1, 2'd0, 5'd31, 6'd0, 1'b0, 32'd0);
    check("R3 pos equals size valid", 64'(resultOut), 64'h0123_4567);
    check("R3 pos equals size flag", 64'(failOut), 64'd0);
    setCtrl(6'd0, 1'b0);
    issue(3'd1, 2'd0, 5'd0, 6'd0, 1'b0, 32'd0);
    check("R2 single bit zero", 64'(resultOut), 64'd1);
    setCtrl(6'd5, 1'b0);
    issue(3'd1, 2'd0, 5'd6, 6'd0, 1'b0, 32'd0);
    check("R3 fail result zero", 64'(resultOut), 64'd0);
    check("R3 fail flag", 64'(failOut), 64'd1);
    check("R4 fail keeps pointer", 64'(posOut), 64'd5);
    issue(3'd6, 2'd0, 5'd0, 6'd0, 1'b0, 32'hFFFF_FFFF);
    check("R11 idle code no strobe", 64'(resultValid), 64'd0);
    check("R11 idle code keeps pointer", 64'(posOut), 64'd5);
    check("R11 idle code keeps flag", 64'(failOut), 64'd1);
  endtask

  task automatic testConsume();
    setCtrl(6'd39, 1'b0);
    issue(3'd2, 2'd0, 5'd7, 6'd0, 1'b0, 32'd0);
    check("R4 consume field", 64'(resultOut), 64'h0000_00EF);
    check("R4 consume pointer", 64'(posOut), 64'd31);
    issue(3'd2, 2'd0, 5'd31, 6'd0, 1'b0, 32'd0);
    check("R4 consume low word", 64'(resultOut), 64'h0123_4567);
    check("R4 consume wraps to 63", 64'(posOut), 64'd63);
    setCtrl(6'd3, 1'b0);
    issue(3'd2, 2'd0, 5'd8, 6'd0, 1'b0, 32'd0);
    check("R4 failing consume keeps pointer", 64'(posOut), 64'd3);
    check("R3 failing consume flag", 64'(failOut), 64'd1);
  endtask

  task automatic testRegOperand();
    setCtrl(6'd47, 1'b0);
    issue(3'd1, 2'd0, 5'd20, 6'd0, 1'b1, 32'hFFFF_FFE3);
    check("R5 size from register", 64'(resultOut), 64'(fieldOf(PATTERN, 47, 3)));
    check("R5 flag", 64'(failOut), 64'd0);
  endtask

  task automatic testShift();
    logic [63:0] m, v;
    m = PATTERN;
    setCtrl(6'd12, 1'b0);
    issue(3'd3, 2'd0, 5'd0, 6'd4, 1'b0, 32'd0);
    m = m >> 4;
    check("R9 right by 4", {accHiOut, accLoOut}, m);
    issue(3'd3, 2'd0, 5'd0, 6'b100000, 1'b0, 32'd0);
    m = m << 32;
    check("R9 left by 32", {accHiOut, accLoOut}, m);
    issue(3'd3, 2'd0, 5'd0, 6'b111100, 1'b0, 32'd0);
    m = m << 4;
    check("R9 left by 4", {accHiOut, accLoOut}, m);
    issue(3'd3, 2'd0, 5'd0, 6'd0, 1'b0, 32'd0);
    check("R9 zero unchanged", {accHiOut, accLoOut}, m);
    issue(3'd3, 2'd0, 5'd0, 6'b111111, 1'b1, 32'hABCD_EF08);
    m = m >> 8;
    check("R5 shift from register", {accHiOut, accLoOut}, m);
    check("R9 shift keeps pointer", 64'(posOut), 64'd12);
    readAcc(2'd2, v);
    check("R10 acc2 untouched by shifts", v, 64'h0000_0011_0000_0022);
    loadAcc(2'd1, 64'h8000_0000_0000_0001);
    issue(3'd3, 2'd1, 5'd0, 6'd31, 1'b0, 32'd0);
    check("R9 right 31 logical", {accHiOut, accLoOut}, 64'h0000_0001_0000_0000);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    testReset();
    testPush();
    testSetCtrl();
    testExtract();
    testConsume();
    testRegOperand();
    testShift();
    repeat (2) @(posedge clk);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule